// File: doc/BRIEF.md
# Triple-Redundant Configuration Register File with I2C Target

This block holds the settings that a mixed-signal driver chip needs. A host sets and reads them over a two-wire serial bus in which the block is a target. There are seven 8-bit registers. Their voted contents drive static control codes: a modulation-current code, a bias-current code, separate emphasis amplitude and timing codes for the rising and the falling edge, and a flag that joins the two output halves in parallel. The digital-to-analog converters that use these codes lie outside the block.

Every stored bit has three copies, and a 2-of-3 majority voter feeds every consumer. On each cycle of the block's free-running core clock, all three copies are loaded from the voted value. A single upset copy is therefore repaired at the next edge, and the repair does not need any activity on the serial clock. A fault hook sets one chosen copy of one bit to the opposite of its voted value. The bench uses it to show that the block tolerates and repairs such a fault. SCL and SDA are sampled in the core clock domain. The target pulls SDA low through an open-drain enable.

Top module: `tmrI2cCfg`

## Requirements
- R1: When rstN is low, all three copies of every register load these defaults: index 0 = 0x20, 1 = 0x40, 2 = 0x25, 3 = 0x25, 4 = 0x00, 5 = 0x00, 6 = 0x00. After reset, sdaOutEn is 0.
- R2: The target answers the write address byte (7-bit address 0x2A, R/W bit 0) by pulling SDA low during the acknowledge clock. It also acknowledges a valid pointer byte and every data byte. Each data byte is loaded into all three copies of the pointed register on the rising SCL edge of its acknowledge clock.
- R3: The first byte after a write address sets the register pointer. After each data byte, read or written, the pointer advances by one and wraps from 6 to 0.
- R4: After an address byte with R/W bit 1, the target sends the voted value of the pointed register, MSB first. It sends the next register after each master acknowledge (SDA low) and stops sending after a master no-acknowledge.
- R5: The target does not acknowledge an address byte that differs from 0x2A. No register changes until the next start condition.
- R6: The target does not acknowledge a pointer byte above 6. No data byte that follows is acknowledged or stored before the next start.
- R7: Field map of the voted registers:
  - modCode is register 0 bits 5:0.
  - biasCode is register 1 bits 7:0.
  - riseAmp is register 2 bits 3:0, and riseTime is register 2 bits 5:4.
  - fallAmp is register 3 bits 3:0, and fallTime is register 3 bits 5:4.
  - parallelEn is register 4 bit 0.
  - All bits of all seven registers read back as written.
- R8: When one copy of one bit is forced wrong (faultEn, with faultIdx, faultBit and faultCopy choosing the copy), neither the field outputs nor a read return a different value.
- R9: A copy that disagrees with the vote is restored at the next core clock edge, with SCL held high. A later fault in a different copy of the same bit then still leaves the output unchanged.
- R10: A stop condition releases SDA (sdaOutEn = 0) and returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also drives the scrubbing |
| rstN | input | 1 | Active-low reset to defaults |
| scl | input | 1 | Serial bus clock |
| sdaIn | input | 1 | Serial data line as seen on the pad |
| sdaOutEn | output | 1 | 1 pulls SDA low (open-drain) |
| faultEn | input | 1 | Force one copy of one bit to the wrong value |
| faultIdx | input | 3 | Register index of the forced bit |
| faultBit | input | 3 | Bit position of the forced bit |
| faultCopy | input | 2 | Copy (0 to 2) to force |
| modCode | output | 6 | Modulation current code |
| biasCode | output | 8 | Bias current code |
| riseAmp | output | 4 | Rising-edge emphasis amplitude |
| riseTime | output | 2 | Rising-edge emphasis timing |
| fallAmp | output | 4 | Falling-edge emphasis amplitude |
| fallTime | output | 2 | Falling-edge emphasis timing |
| parallelEn | output | 1 | Join both output halves in parallel |

## Verification
The assertions assume that at most one copy of any bit is wrong at a time, and that a fault is never forced during the same cycle as a bus write. The copy-agreement and vote-stability properties hold only under that assumption. The stimulus raises faultEn for single cycles and only while SCL and SDA sit idle. It leaves at least two core cycles between faults on the same bit, so each repair finishes before the next copy is disturbed. The master model keeps every SCL phase many core cycles long. As a result, the synchronised edges and the target's SDA response always settle before the master samples.

// File: rtl/tmrCfgPkg.sv
package tmrCfgPkg;
  localparam int NUM_REGS = 7;
  localparam int REG_W    = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int BIT_W    = $clog2(REG_W);
  localparam int COPIES   = 3;

  typedef logic [NUM_REGS-1:0][REG_W-1:0] regArray_t;

  // Write strobe from the bus control to the storage.
  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [REG_W-1:0] wrData;
  } cfgStrobe_t;

  function automatic logic [REG_W-1:0] resetValue(input int idx);
    case (idx)
      0:       return REG_W'(8'h20);
      1:       return REG_W'(8'h40);
      2, 3:    return REG_W'(8'h25);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/tmrVoter.sv
module tmrVoter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/tmrRegBank.sv
module tmrRegBank
  import tmrCfgPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       strobe,
  input  logic             faultEn,
  input  logic [IDX_W-1:0] faultIdx,
  input  logic [BIT_W-1:0] faultBit,
  input  logic [1:0]       faultCopy,
  output regArray_t        voted,
  output regArray_t [COPIES-1:0] copies
);
  regArray_t [COPIES-1:0] nxtCopy;

  for (genvar r = 0; r < NUM_REGS; r++) begin : gVote
    tmrVoter #(.W(REG_W)) voterInst (
      .a(copies[0][r]),
      .b(copies[1][r]),
      .c(copies[2][r]),
      .y(voted[r])
    );
  end

  // Every copy reloads from the vote each core cycle; a write overrides,
  // and the fault hook flips one chosen copy bit last.
  always_comb begin
    for (int c = 0; c < COPIES; c++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        nxtCopy[c][r] = voted[r];
        if (strobe.wrEn && strobe.wrIdx == IDX_W'(r))
          nxtCopy[c][r] = strobe.wrData;
        if (faultEn && faultCopy == 2'(c) && faultIdx == IDX_W'(r))
          nxtCopy[c][r][faultBit] = ~voted[r][faultBit];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < COPIES; c++)
        for (int r = 0; r < NUM_REGS; r++)
          copies[c][r] <= resetValue(r);
    end else begin
      copies <= nxtCopy;
    end
  end
endmodule

// File: rtl/i2cTargetCtrl.sv
module i2cTargetCtrl
  import tmrCfgPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  regArray_t  voted,
  output logic       sdaOutEn,
  output cfgStrobe_t strobe
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } busState_t;

  busState_t        state;
  logic [2:0]       sclSync, sdaSync;
  logic [3:0]       bitCnt;
  logic [REG_W-1:0] shiftIn;
  logic [REG_W-2:0] txBits;
  logic [IDX_W-1:0] ptr, ptrNext;
  logic             isRead, masterAck;
  logic             sclRise, sclFall, startCond, stopCond, sdaNow;

  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclSync[1] & ~sclSync[2];
  assign sclFall   = ~sclSync[1] & sclSync[2];
  assign startCond = sclSync[1] & sclSync[2] & ~sdaSync[1] & sdaSync[2];
  assign stopCond  = sclSync[1] & sclSync[2] & sdaSync[1] & ~sdaSync[2];
  assign ptrNext   = (ptr == IDX_W'(NUM_REGS-1)) ? '0 : ptr + 1'b1;

  assign strobe.wrEn   = (state == ST_WR_ACK) && sclRise;
  assign strobe.wrIdx  = ptr;
  assign strobe.wrData = shiftIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[1:0], scl};
      sdaSync <= {sdaSync[1:0], sdaIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftIn   <= '0;
      txBits    <= '0;
      ptr       <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      sdaOutEn  <= 1'b0;
    end else if (stopCond) begin
      state    <= ST_IDLE;
      sdaOutEn <= 1'b0;
    end else if (startCond) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      sdaOutEn <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (sclRise) begin
            shiftIn <= {shiftIn[REG_W-2:0], sdaNow};
            bitCnt  <= bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCnt <= '0;
            if (state == ST_ADDR) begin
              if (shiftIn[7:1] == DEV_ADDR) begin
                isRead   <= shiftIn[0];
                sdaOutEn <= 1'b1;
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_PTR) begin
              if (shiftIn < REG_W'(NUM_REGS)) begin
                ptr      <= shiftIn[IDX_W-1:0];
                sdaOutEn <= 1'b1;
                state    <= ST_PTR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sdaOutEn <= 1'b1;
              state    <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          if (isRead) begin
            txBits   <= voted[ptr][REG_W-2:0];
            sdaOutEn <= ~voted[ptr][REG_W-1];
            bitCnt   <= 4'd1;
            state    <= ST_RD;
          end else begin
            sdaOutEn <= 1'b0;
            state    <= ST_PTR;
          end
        end
        ST_PTR_ACK: if (sclFall) begin
          sdaOutEn <= 1'b0;
          state    <= ST_WR;
        end
        ST_WR_ACK: begin
          if (sclRise) ptr <= ptrNext;
          else if (sclFall) begin
            sdaOutEn <= 1'b0;
            state    <= ST_WR;
          end
        end
        ST_RD: if (sclFall) begin
          if (bitCnt == 4'd8) begin
            sdaOutEn <= 1'b0;
            state    <= ST_RD_ACK;
          end else begin
            sdaOutEn <= ~txBits[REG_W-2];
            txBits   <= {txBits[REG_W-3:0], 1'b0};
            bitCnt   <= bitCnt + 1'b1;
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            ptr       <= ptrNext;
            masterAck <= ~sdaNow;
          end else if (sclFall) begin
            if (masterAck) begin
              txBits   <= voted[ptr][REG_W-2:0];
              sdaOutEn <= ~voted[ptr][REG_W-1];
              bitCnt   <= 4'd1;
              state    <= ST_RD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tmrI2cCfg.sv
module tmrI2cCfg
  import tmrCfgPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scl,
  input  logic             sdaIn,
  output logic             sdaOutEn,
  input  logic             faultEn,
  input  logic [IDX_W-1:0] faultIdx,
  input  logic [BIT_W-1:0] faultBit,
  input  logic [1:0]       faultCopy,
  output logic [5:0]       modCode,
  output logic [7:0]       biasCode,
  output logic [3:0]       riseAmp,
  output logic [1:0]       riseTime,
  output logic [3:0]       fallAmp,
  output logic [1:0]       fallTime,
  output logic             parallelEn
);
  cfgStrobe_t             ctrlStrobe;
  regArray_t              votedRegs;
  regArray_t [COPIES-1:0] copyRegs;

  i2cTargetCtrl #(.DEV_ADDR(DEV_ADDR)) ctrlInst (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn),
    .voted(votedRegs), .sdaOutEn(sdaOutEn), .strobe(ctrlStrobe)
  );

  tmrRegBank bankInst (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe),
    .faultEn(faultEn), .faultIdx(faultIdx), .faultBit(faultBit),
    .faultCopy(faultCopy), .voted(votedRegs), .copies(copyRegs)
  );

  assign modCode    = votedRegs[0][5:0];
  assign biasCode   = votedRegs[1];
  assign riseAmp    = votedRegs[2][3:0];
  assign riseTime   = votedRegs[2][5:4];
  assign fallAmp    = votedRegs[3][3:0];
  assign fallTime   = votedRegs[3][5:4];
  assign parallelEn = votedRegs[4][0];
endmodule

// File: rtl/tmrI2cCfgChk.sv
module tmrI2cCfgChk
  import tmrCfgPkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input cfgStrobe_t             strobe,
  input logic                   faultEn,
  input regArray_t              voted,
  input regArray_t [COPIES-1:0] copies
);
  // R9: with no fault forced, all copies agree one cycle later
  assert_copies_agree_R9: assert property (@(posedge clk) disable iff (!rstN)
    !faultEn |=> (copies[0] == copies[1] && copies[1] == copies[2]));

  // R8: without a write, the voted contents never move (single faults masked)
  assert_vote_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(voted));

  // R2: a write lands in every copy of the pointed register
  assert_write_triplicate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !faultEn) |=>
      (copies[0][$past(strobe.wrIdx)] == $past(strobe.wrData) &&
       copies[1][$past(strobe.wrIdx)] == $past(strobe.wrData) &&
       copies[2][$past(strobe.wrIdx)] == $past(strobe.wrData)));

  // R3: the pointer never addresses a register beyond index 6
  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (int'(strobe.wrIdx) < NUM_REGS));
endmodule

bind tmrI2cCfg tmrI2cCfgChk chkInst (
  .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .faultEn(faultEn),
  .voted(votedRegs), .copies(copyRegs)
);

// File: tb/tmrI2cCfg_test.sv
module tmrI2cCfg_test;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h2A;

  typedef struct packed { logic [2:0] idx; logic [7:0] val; } vec_t;
  localparam vec_t VECS [8] = '{
    '{3'd0, 8'hFF}, '{3'd1, 8'hA5}, '{3'd2, 8'h3C}, '{3'd3, 8'hC7},
    '{3'd4, 8'h01}, '{3'd5, 8'h5A}, '{3'd6, 8'h81}, '{3'd4, 8'hFE}
  };

  logic clk = 0, rstN = 0, scl = 1, mLow = 0;
  logic faultEn = 0;
  logic [2:0] faultIdx = 0, faultBit = 0;
  logic [1:0] faultCopy = 0;
  logic sdaOutEn, sdaLine, parallelEn;
  logic [5:0] modCode;
  logic [7:0] biasCode;
  logic [3:0] riseAmp, fallAmp;
  logic [1:0] riseTime, fallTime;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sdaLine = ~(mLow | sdaOutEn);

  tmrI2cCfg uut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine), .sdaOutEn(sdaOutEn),
    .faultEn(faultEn), .faultIdx(faultIdx), .faultBit(faultBit),
    .faultCopy(faultCopy), .modCode(modCode), .biasCode(biasCode),
    .riseAmp(riseAmp), .riseTime(riseTime), .fallAmp(fallAmp),
    .fallTime(fallTime), .parallelEn(parallelEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mLow = 0; qw(); scl = 1; qw(); mLow = 1; qw(); scl = 0; qw();
  endtask

  task automatic busStop();
    mLow = 1; qw(); scl = 1; qw(); mLow = 0; qw();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mLow = ~b[i]; qw(); scl = 1; qw(); qw(); scl = 0; qw();
    end
    mLow = 0; qw(); scl = 1; qw(); ack = sdaLine; qw(); scl = 0; qw();
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    mLow = 0;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1; qw(); b[i] = sdaLine; qw(); scl = 0; qw();
    end
    mLow = ~nack; qw(); scl = 1; qw(); qw(); scl = 0; qw(); mLow = 0;
  endtask

  task automatic writeReg(input logic [2:0] idx, input logic [7:0] val, output logic [2:0] acks);
    busStart();
    sendByte({ADDR, 1'b0}, acks[2]);
    sendByte({5'd0, idx}, acks[1]);
    sendByte(val, acks[0]);
    busStop();
  endtask

  task automatic readReg(input logic [2:0] idx, output logic [7:0] val);
    logic a;
    busStart();
    sendByte({ADDR, 1'b0}, a);
    sendByte({5'd0, idx}, a);
    busStart();
    sendByte({ADDR, 1'b1}, a);
    recvByte(1'b1, val);
    busStop();
  endtask

  function automatic logic [7:0] fieldView(input logic [2:0] idx);
    case (idx)
      3'd0: return {2'b0, modCode};
      3'd1: return biasCode;
      3'd2: return {2'b0, riseTime, riseAmp};
      3'd3: return {2'b0, fallTime, fallAmp};
      default: return {7'b0, parallelEn};
    endcase
  endfunction

  function automatic logic [7:0] fieldMask(input logic [2:0] idx);
    case (idx)
      3'd1: return 8'hFF;
      3'd4: return 8'h01;
      default: return 8'h3F;
    endcase
  endfunction

  task automatic pulseFault(input logic [2:0] idx, input logic [2:0] bitPos, input logic [1:0] copy);
    @(negedge clk);
    faultIdx = idx; faultBit = bitPos; faultCopy = copy; faultEn = 1;
    @(negedge clk);
    faultEn = 0;
  endtask

  initial begin
    logic [2:0] acks;
    logic [7:0] rd, b0, b1, b2;
    logic a, a2;
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);

    // R1: defaults on the outputs and through a read
    check("R1 modCode", modCode, 6'h20);
    check("R1 biasCode", biasCode, 8'h40);
    check("R1 rise", {riseTime, riseAmp}, 6'h25);
    check("R1 fall", {fallTime, fallAmp}, 6'h25);
    check("R1 parallelEn", parallelEn, 1'b0);
    check("R1 sdaOutEn", sdaOutEn, 1'b0);
    readReg(3'd2, rd);
    check("R1 read reg2", rd, 8'h25);

    // Vector table: write, read back (R4), field map (R7), acks (R2)
    foreach (VECS[i]) begin
      writeReg(VECS[i].idx, VECS[i].val, acks);
      check("R2 write acks", acks, 3'b000);
      check("R10 sda released after stop", sdaOutEn, 1'b0);
      readReg(VECS[i].idx, rd);
      check("R4 R7 readback", rd, VECS[i].val);
      if (VECS[i].idx < 3'd5)
        check("R7 field", fieldView(VECS[i].idx), VECS[i].val & fieldMask(VECS[i].idx));
    end

    // R3: burst write wraps 5 -> 6 -> 0
    busStart();
    sendByte({ADDR, 1'b0}, a); sendByte(8'd5, a);
    sendByte(8'h11, a); sendByte(8'h22, a); sendByte(8'h33, a2);
    busStop();
    check("R3 last burst ack", a2, 1'b0);
    check("R3 wrapped write to reg0", modCode, 6'h33);

    // R3 R4: burst read from 5 wraps too
    busStart();
    sendByte({ADDR, 1'b0}, a); sendByte(8'd5, a);
    busStart();
    sendByte({ADDR, 1'b1}, a);
    recvByte(1'b0, b0); recvByte(1'b0, b1); recvByte(1'b1, b2);
    busStop();
    check("R4 burst read reg5", b0, 8'h11);
    check("R4 burst read reg6", b1, 8'h22);
    check("R3 burst read wrap reg0", b2, 8'h33);
    check("R10 idle after read stop", sdaOutEn, 1'b0);

    // R5: foreign address ignored
    busStart();
    sendByte({7'h2B, 1'b0}, a); sendByte(8'd1, a2); sendByte(8'h77, a2);
    busStop();
    check("R5 address nack", a, 1'b1);
    check("R5 bias unchanged", biasCode, 8'hA5);

    // R6: pointer above 6 refused, following data ignored
    busStart();
    sendByte({ADDR, 1'b0}, a); sendByte(8'd7, a); sendByte(8'h00, a2);
    busStop();
    check("R6 pointer nack", a, 1'b1);
    check("R6 data nack", a2, 1'b1);
    check("R6 reg0 unchanged", modCode, 6'h33);
    check("R6 bias unchanged", biasCode, 8'hA5);
    check("R6 rise unchanged", {riseTime, riseAmp}, 6'h3C);

    // R8 R9: single upsets masked and scrubbed with SCL idle (high)
    pulseFault(3'd1, 3'd3, 2'd0);
    check("R8 bias after copy0 upset", biasCode, 8'hA5);
    repeat (2) @(negedge clk);
    pulseFault(3'd1, 3'd3, 2'd1);
    check("R9 bias after copy1 upset", biasCode, 8'hA5);
    repeat (2) @(negedge clk);
    pulseFault(3'd1, 3'd3, 2'd2);
    check("R9 bias after copy2 upset", biasCode, 8'hA5);
    repeat (2) @(negedge clk);
    pulseFault(3'd0, 3'd5, 2'd2);
    readReg(3'd0, rd);
    check("R8 read returns voted value", rd, 8'h33);
    pulseFault(3'd0, 3'd5, 2'd0);
    repeat (2) @(negedge clk);
    check("R9 modCode after second upset", modCode, 6'h33);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule